// File: doc/BRIEF.md
# Jumperless I/O Base Unlock

This block lets host software give an expansion card its I/O base address with no jumpers. When the strap input selects jumperless mode, the block watches host bus cycles aimed at a fixed legacy port address, 0x278. That address is the data register of a printer port, so the block borrows it. The block counts write cycles to the port that follow one another. On the fourth such write, it loads the low bits of the written data into the I/O base field and raises an enabled flag. From then on, the card answers bus cycles inside its new base window.

The unlock is a one-shot. It can succeed only once per power-on reset. An ordinary reset returns the card to the disabled state but keeps the used mark, so no second unlock can happen until power-on reset is applied again. Before the unlock, the block never claims any address, so a real printer port at 0x278 keeps working.

Top module: `jl_base_unlock`

## Requirements
- R1: After power-on reset, `unlocked` is 0, `io_base` is 0 and `cfg_sel` is 0.
- R2: In jumperless mode (`jumperless_mode`=1), four write cycles to address 0x278 with no other bus cycle between them set `unlocked` to 1 and load `bus_data[4:0]` of the fourth write into `io_base`. Both take effect at the clock edge that samples the fourth write.
- R3: Three consecutive writes to 0x278 leave `unlocked` at 0.
- R4: A bus cycle (read or write) to any address other than 0x278 restarts the count, so four more writes are needed.
- R5: A read cycle of 0x278 restarts the count.
- R6: Clocks with `bus_cycle`=0 between the writes neither advance nor restart the count.
- R7: With `jumperless_mode`=0, writes to 0x278 have no effect and leave no partial count behind.
- R8: After the unlock, further writes to 0x278 and a drop of `jumperless_mode` leave `io_base` and `unlocked` unchanged.
- R9: `cfg_sel` is 1 only while `unlocked`=1 and a bus cycle has `bus_addr[9:5]` equal to `io_base`. Before the unlock it is 0 for every address, including 0x278.
- R10: An ordinary reset (`rst_n` low) clears `unlocked` but keeps `io_base`. A complete four-write sequence after it does not unlock again.
- R11: Power-on reset clears the one-shot mark, so a new four-write sequence unlocks again with new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | Ordinary reset, asynchronous, active low |
| jumperless_mode | input | 1 | Strap input that selects jumperless base configuration |
| bus_cycle | input | 1 | A host bus cycle is present in this clock |
| bus_wr | input | 1 | The bus cycle is a write (1) or a read (0) |
| bus_addr | input | 10 | Host I/O address |
| bus_data | input | 8 | Host write data |
| io_base | output | 5 | Latched I/O base, equal to address bits 9:5 |
| unlocked | output | 1 | Base has been committed and the card is enabled |
| cfg_sel | output | 1 | The current bus cycle falls in the card's base window |

## Verification
The unlock sequence is driven with several patterns:
- A clean run of four writes.
- Runs broken by a read of the port.
- Runs broken by a write elsewhere.
- Runs spread out by idle clocks.

These patterns separate a counter that resets on the right events from one that counts every strobe or ignores breaks. Runs with the mode strap low and runs after an ordinary reset show whether the arming conditions and the one-shot mark are honoured. Repeat writes after the unlock show whether the committed base is protected. Probes of `cfg_sel` at the port address and at the new window show that the block claims nothing before the commit and decodes the new base after it.

// File: rtl/jl_unlock_pkg.sv
package jl_unlock_pkg;

  // Classification of one bus clock as seen by the write-sequence counter.
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,  // no bus cycle this clock
    EV_HIT  = 2'd1,  // write to the legacy port
    EV_MISS = 2'd2   // any other bus cycle
  } bus_ev_e;

endpackage

// File: rtl/jl_rst_sync.sv
module jl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  // Asserts at once, releases after STAGES clock edges.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/jl_seq_counter.sv
module jl_seq_counter
  import jl_unlock_pkg::*;
#(
  parameter int WRITES = 4,
  localparam int CNT_W = (WRITES > 2) ? $clog2(WRITES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  bus_ev_e          ev,
  output logic [CNT_W-1:0] cnt,
  output logic             commit
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    commit = 1'b0;
    if (!armed) begin
      cnt_d = '0;
    end else begin
      unique case (ev)
        EV_HIT: begin
          if (cnt_q == LAST) begin
            cnt_d  = '0;
            commit = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        EV_MISS: cnt_d = '0;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/jl_base_reg.sv
module jl_base_reg #(
  parameter int BASE_W = 5
) (
  input  logic              clk,
  input  logic              por_rst_n,
  input  logic              sys_rst_n,
  input  logic              commit,
  input  logic [BASE_W-1:0] base_in,
  output logic [BASE_W-1:0] base_q,
  output logic              enabled_q,
  output logic              used_q
);

  logic [BASE_W-1:0] base_r;
  logic              used_r;
  logic              en_r;
  logic              en_d;

  // Base value and one-shot mark survive ordinary reset.
  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) begin
      base_r <= '0;
      used_r <= 1'b0;
    end else if (commit) begin
      base_r <= base_in;
      used_r <= 1'b1;
    end
  end

  always_comb begin
    en_d = en_r | commit;
  end

  // Enabled flag is cleared by either reset.
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      en_r <= 1'b0;
    end else begin
      en_r <= en_d;
    end
  end

  assign base_q    = base_r;
  assign enabled_q = en_r;
  assign used_q    = used_r;

endmodule

// File: rtl/jl_base_unlock.sv
module jl_base_unlock
  import jl_unlock_pkg::*;
#(
  parameter int              ADDR_W      = 10,
  parameter int              DATA_W      = 8,
  parameter int              BASE_LSB    = 5,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 10'h278,
  parameter int              WRITES      = 4,
  parameter int              SYNC_STAGES = 2,
  localparam int             BASE_W      = ADDR_W - BASE_LSB,
  localparam int             CNT_W       = (WRITES > 2) ? $clog2(WRITES) : 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              jumperless_mode,
  input  logic              bus_cycle,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic [BASE_W-1:0] io_base,
  output logic              unlocked,
  output logic              cfg_sel
);

  logic             por_srst_n;
  logic             sys_arst_n;
  logic             sys_srst_n;
  bus_ev_e          bus_ev;
  logic             armed;
  logic             commit;
  logic             used_q;
  logic [CNT_W-1:0] seq_cnt;

  assign sys_arst_n = rst_n & por_n;

  jl_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (por_srst_n)
  );

  jl_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_sync (
    .clk    (clk),
    .arst_n (sys_arst_n),
    .srst_n (sys_srst_n)
  );

  always_comb begin
    if (!bus_cycle) begin
      bus_ev = EV_NONE;
    end else if (bus_wr && (bus_addr == PORT_ADDR)) begin
      bus_ev = EV_HIT;
    end else begin
      bus_ev = EV_MISS;
    end
  end

  assign armed = jumperless_mode & ~used_q;

  jl_seq_counter #(.WRITES(WRITES)) u_seq (
    .clk    (clk),
    .rst_n  (sys_srst_n),
    .armed  (armed),
    .ev     (bus_ev),
    .cnt    (seq_cnt),
    .commit (commit)
  );

  jl_base_reg #(.BASE_W(BASE_W)) u_base (
    .clk       (clk),
    .por_rst_n (por_srst_n),
    .sys_rst_n (sys_srst_n),
    .commit    (commit),
    .base_in   (bus_data[BASE_W-1:0]),
    .base_q    (io_base),
    .enabled_q (unlocked),
    .used_q    (used_q)
  );

  assign cfg_sel = unlocked & bus_cycle &
                   (bus_addr[ADDR_W-1:BASE_LSB] == io_base);

endmodule

// File: rtl/jl_base_unlock_chk.sv
module jl_base_unlock_chk #(
  parameter int                ADDR_W    = 10,
  parameter int                BASE_W    = 5,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 10'h278,
  parameter int                WRITES    = 4,
  parameter int                CNT_W     = 2
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              jumperless_mode,
  input logic              bus_cycle,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  seq_cnt,
  input logic              used_q,
  input logic [BASE_W-1:0] io_base,
  input logic              unlocked,
  input logic              cfg_sel
);

  logic port_wr;
  assign port_wr = bus_cycle && bus_wr && (bus_addr == PORT_ADDR);

  p_commit_r2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (jumperless_mode && !used_q && port_wr && seq_cnt == CNT_W'(WRITES - 1)) |=> unlocked);

  p_rise_needs_write_r2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(unlocked) |-> $past(port_wr && jumperless_mode));

  p_restart_r4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (bus_cycle && !port_wr) |=> (seq_cnt == '0));

  p_mode_off_r7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (!jumperless_mode && !unlocked) |=> !unlocked);

  p_base_hold_r8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $past(unlocked) |-> $stable(io_base));

  p_no_claim_r9: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !unlocked |-> !cfg_sel);

  p_one_shot_r10: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (used_q && !unlocked) |=> !unlocked);

endmodule

bind jl_base_unlock jl_base_unlock_chk #(
  .ADDR_W    (ADDR_W),
  .BASE_W    (BASE_W),
  .PORT_ADDR (PORT_ADDR),
  .WRITES    (WRITES),
  .CNT_W     (CNT_W)
) u_chk (
  .clk             (clk),
  .por_n           (por_n),
  .rst_n           (rst_n),
  .jumperless_mode (jumperless_mode),
  .bus_cycle       (bus_cycle),
  .bus_wr          (bus_wr),
  .bus_addr        (bus_addr),
  .seq_cnt         (seq_cnt),
  .used_q          (used_q),
  .io_base         (io_base),
  .unlocked        (unlocked),
  .cfg_sel         (cfg_sel)
);

// File: tb/jl_base_unlock_bench.sv
module jl_base_unlock_bench;

  logic       clk;
  logic       por_n;
  logic       rst_n;
  logic       jumperless_mode;
  logic       bus_cycle;
  logic       bus_wr;
  logic [9:0] bus_addr;
  logic [7:0] bus_data;
  logic [4:0] io_base;
  logic       unlocked;
  logic       cfg_sel;

  int errors = 0;
  int checks = 0;
  logic sel_seen;
  logic finished = 1'b0;

  jl_base_unlock u_jl_base_unlock (
    .clk             (clk),
    .por_n           (por_n),
    .rst_n           (rst_n),
    .jumperless_mode (jumperless_mode),
    .bus_cycle       (bus_cycle),
    .bus_wr          (bus_wr),
    .bus_addr        (bus_addr),
    .bus_data        (bus_data),
    .io_base         (io_base),
    .unlocked        (unlocked),
    .cfg_sel         (cfg_sel)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // Vector: mode[26] cyc[25] wr[24] addr[23:14] data[13:6] exp_unlocked[5] exp_base[4:0]
  localparam int NV = 15;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b1, 10'h278, 8'h11, 1'b0, 5'h00},  // write 1
    {1'b1, 1'b1, 1'b1, 10'h278, 8'h11, 1'b0, 5'h00},  // write 2
    {1'b1, 1'b1, 1'b0, 10'h278, 8'h00, 1'b0, 5'h00},  // R5 read restarts
    {1'b1, 1'b1, 1'b1, 10'h278, 8'h01, 1'b0, 5'h00},  // write 1
    {1'b1, 1'b1, 1'b1, 10'h278, 8'h01, 1'b0, 5'h00},  // write 2
    {1'b1, 1'b1, 1'b1, 10'h278, 8'h01, 1'b0, 5'h00},  // R3 write 3, no unlock
    {1'b1, 1'b1, 1'b1, 10'h300, 8'h00, 1'b0, 5'h00},  // R4 other address restarts
    {1'b1, 1'b0, 1'b0, 10'h000, 8'h00, 1'b0, 5'h00},  // idle
    {1'b1, 1'b1, 1'b1, 10'h278, 8'h01, 1'b0, 5'h00},  // write 1
    {1'b1, 1'b0, 1'b0, 10'h278, 8'h00, 1'b0, 5'h00},  // R6 idle in between
    {1'b1, 1'b1, 1'b1, 10'h278, 8'h01, 1'b0, 5'h00},  // write 2
    {1'b1, 1'b1, 1'b1, 10'h278, 8'h01, 1'b0, 5'h00},  // write 3
    {1'b1, 1'b1, 1'b1, 10'h278, 8'h2A, 1'b1, 5'h0A},  // R2 write 4 commits
    {1'b1, 1'b1, 1'b1, 10'h278, 8'h1F, 1'b1, 5'h0A},  // R8 later write ignored
    {1'b0, 1'b1, 1'b1, 10'h278, 8'h05, 1'b1, 5'h0A}   // R8 mode drop ignored
  };

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus clock: drive at negedge, sample cfg_sel mid-cycle, return after the edge.
  task automatic cyc(input logic m, input logic c, input logic w,
                     input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    jumperless_mode = m;
    bus_cycle = c;
    bus_wr = w;
    bus_addr = a;
    bus_data = d;
    #2;
    sel_seen = cfg_sel;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cyc(jumperless_mode, 1'b0, 1'b0, 10'h000, 8'h00);
  endtask

  task automatic do_por();
    @(negedge clk);
    bus_cycle = 1'b0;
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_rst();
    @(negedge clk);
    bus_cycle = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic four_writes(input logic [7:0] d);
    for (int k = 0; k < 4; k++) cyc(1'b1, 1'b1, 1'b1, 10'h278, d);
  endtask

  initial begin
    por_n = 1'b0;
    rst_n = 1'b1;
    jumperless_mode = 1'b1;
    bus_cycle = 1'b0;
    bus_wr = 1'b0;
    bus_addr = '0;
    bus_data = '0;
    sel_seen = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", {unlocked, io_base}, 6'h00);
    check("R1 cfg_sel", {5'h0, cfg_sel}, 6'h00);

    // R9 no claim of port or window before unlock
    cyc(1'b1, 1'b1, 1'b0, 10'h278, 8'h00);
    check("R9 port read pre-unlock", {5'h0, sel_seen}, 6'h00);
    cyc(1'b1, 1'b1, 1'b0, 10'h005, 8'h00);
    check("R9 window pre-unlock", {5'h0, sel_seen}, 6'h00);

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      if (i == 2) tag = "R5";
      else if (i < 6) tag = "R3";
      else if (i < 12) tag = "R4/R6";
      else if (i == 12) tag = "R2";
      else tag = "R8";
      cyc(VEC[i][26], VEC[i][25], VEC[i][24], VEC[i][23:14], VEC[i][13:6]);
      check(tag, {unlocked, io_base}, VEC[i][5:0]);
    end

    // R9 decode at new base 0x0A -> addresses 0x140..0x15F
    cyc(1'b1, 1'b1, 1'b0, 10'h14C, 8'h00);
    check("R9 new window", {5'h0, sel_seen}, 6'h01);
    cyc(1'b1, 1'b1, 1'b0, 10'h278, 8'h00);
    check("R9 old port", {5'h0, sel_seen}, 6'h00);
    cyc(1'b1, 1'b0, 1'b0, 10'h140, 8'h00);
    check("R9 no cycle", {5'h0, sel_seen}, 6'h00);

    // R10 ordinary reset keeps base, blocks second unlock
    do_rst();
    check("R10 after reset", {unlocked, io_base}, {1'b0, 5'h0A});
    four_writes(8'h07);
    check("R10 no relock", {unlocked, io_base}, {1'b0, 5'h0A});

    // R11 power-on reset rearms
    do_por();
    check("R11 after por", {unlocked, io_base}, 6'h00);
    four_writes(8'h13);
    check("R11 unlock again", {unlocked, io_base}, {1'b1, 5'h13});

    // R7 mode off: writes ignored, no partial count
    do_por();
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, 1'b1, 10'h278, 8'h04);
    cyc(1'b0, 1'b1, 1'b1, 10'h278, 8'h04);
    check("R7 mode off", {unlocked, io_base}, 6'h00);
    cyc(1'b1, 1'b1, 1'b1, 10'h278, 8'h04);
    check("R7 no leftover count", {unlocked, io_base}, 6'h00);
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b1, 1'b1, 10'h278, 8'h16);
    check("R2 exact fourth", {unlocked, io_base}, {1'b1, 5'h16});

    idle();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule